// File: doc/BRIEF.md
# SPI ADC Control-Byte Responder

This block is a digital behavioural model of a serial 8-bit multi-channel analog-to-digital converter that sits on an SPI bus as a slave. Each byte the master clocks in is examined; a byte whose top bit is set is a command. A command picks an input channel, chooses between a measurement against a zero common reference or against the neighbouring channel of its pair, chooses straight binary or offset (bipolar) coding, and may put the converter to sleep. The 8-bit result is computed at once from a bank of input registers and handed back over the next two bytes, upper six bits first.

The input registers are preset at reset to a descending ramp and can be overwritten at any time through a simple write port, which lets the surrounding model feed in "analog" values. A parameter chooses a 4-input or an 8-input converter; the two differ in how the select bits of the command map to a channel number. An interrupt output marks a finished conversion.

Top module: `spi_adc_responder`

## Requirements
- R1: After reset the input registers hold 0xF0 for channel 0, falling by 0x10 per channel (0x80 for channel 7); the miso and irq outputs are 0 and no conversion result is pending.
- R2: SPI mode 0, most significant bit first: mosi is sampled on each rising sclk edge while csN is low, a byte completes on the eighth such edge, miso changes on falling edges, and raising csN discards a partly received byte.
- R3: A received byte with bit 7 equal to 0 is not a command: the pending result and its read position are left as they were (apart from the position advancing by one byte).
- R4: A command (bit 7 = 1) with bit 1 (power-up) equal to 0 cancels any pending result; every later response byte is 0x00 until a new power-up command arrives, and no interrupt is raised.
- R5: The byte that carries a power-up command returns 0x00; the next byte returns {2'b00, m[7:2]}, the one after returns {m[1:0], 6'b0}, and further bytes return 0x00. The read position survives csN going high.
- R6: With 8 inputs the channel number is {bit 5, bit 4, bit 6} of the command, bit 5 being the most significant.
- R7: With 4 inputs bit 4 of the command is ignored and the channel number is {bit 5, bit 6}.
- R8: With bit 2 equal to 1 the measurement is the selected input minus a common reference of 0.
- R9: With bit 2 equal to 0 the measurement is the selected input minus the input whose channel number differs only in bit 0, wrapping modulo 256.
- R10: With bit 3 equal to 0 bit 7 of the measurement is inverted before it is split; with bit 3 equal to 1 it is used unchanged.
- R11: irq rises after each power-up command byte and falls when csN goes high or when a byte with bit 7 equal to 0 completes.
- R12: A pulse on wrEn stores wrData into input register wrCh; later conversions use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SPI lines are sampled on it |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| wrEn | input | 1 | Input-register write strobe |
| wrCh | input | $clog2(NUM_CH) | Channel written by wrEn |
| wrData | input | 8 | Value written by wrEn |
| irq | output | 1 | Conversion-done interrupt |

## Verification
The bench walks every select code through both the 8-input and the 4-input variant, so a swapped select bit shows up as a result from the wrong default input. Differential measurements are taken in both directions of a pair, so a design that saturated instead of wrapping would return 0x00 instead of 0xF0-style values, and bipolar cases catch a flip of the wrong bit. Non-command filler bytes, a power-down command, a chip-select break in the middle of a read-out and an aborted half byte check that the result sequence is neither disturbed nor misaligned, and that irq drops where it should.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
  localparam int BYTE_W = 8;

  // Control-byte bit positions (decoded by both control and datapath)
  localparam int POS_START = 7;
  localparam int POS_SEL2  = 6;
  localparam int POS_SEL1  = 5;
  localparam int POS_SEL0  = 4;
  localparam int POS_UNI   = 3;
  localparam int POS_SGL   = 2;
  localparam int POS_PWR   = 1;

  // Strobes from the serial control to the conversion datapath
  typedef struct packed {
    logic       latchCmd;     // power-up command byte completed
    logic       clearCmd;     // power-down command byte completed
    logic [2:0] chSel;        // {sel2, sel1, sel0}
    logic       unipolar;
    logic       singleEnded;
  } ctrlStrobe_t;
endpackage

// File: rtl/spi_adc_ctrl.sv
module spi_adc_ctrl
  import spi_adc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic                mosi,
  input  logic                cmdValid,
  input  logic [BYTE_W-1:0]   resFirst,
  input  logic [BYTE_W-1:0]   resSecond,
  output logic                miso,
  output logic                irq,
  output ctrlStrobe_t         strobe
);
  localparam int BIT_CW = $clog2(BYTE_W);

  logic              sclkQ, csNQ, loadQ;
  logic [BIT_CW-1:0] bitCnt;
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [1:0]        respIdx;
  logic [BYTE_W-1:0] rxByte, respNext;
  logic              sclkRise, sclkFall, csFall, csRise, byteDone, isStart;

  assign sclkRise = !csN && sclk && !sclkQ;
  assign sclkFall = !csN && !sclk && sclkQ;
  assign csFall   = !csN && csNQ;
  assign csRise   = csN && !csNQ;
  assign byteDone = sclkRise && (bitCnt == BIT_CW'(BYTE_W - 1));
  assign rxByte   = {rxShift, mosi};
  assign isStart  = rxByte[POS_START];

  always_comb begin
    strobe.latchCmd    = byteDone && isStart && rxByte[POS_PWR];
    strobe.clearCmd    = byteDone && isStart && !rxByte[POS_PWR];
    strobe.chSel       = {rxByte[POS_SEL2], rxByte[POS_SEL1], rxByte[POS_SEL0]};
    strobe.unipolar    = rxByte[POS_UNI];
    strobe.singleEnded = rxByte[POS_SGL];
  end

  always_comb begin
    respNext = '0;
    if (cmdValid) begin
      case (respIdx)
        2'd1:    respNext = resFirst;
        2'd2:    respNext = resSecond;
        default: respNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ   <= 1'b0;
      csNQ    <= 1'b1;
      loadQ   <= 1'b0;
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      respIdx <= '0;
      irq     <= 1'b0;
    end else begin
      sclkQ <= sclk;
      csNQ  <= csN;
      loadQ <= byteDone;

      if (csN) bitCnt <= '0;
      else if (sclkRise) begin
        bitCnt  <= bitCnt + 1'b1;
        rxShift <= rxByte[BYTE_W-2:0];
      end

      if (byteDone) begin
        if (isStart) respIdx <= 2'd1;
        else if (respIdx != 2'd3) respIdx <= respIdx + 2'd1;
      end

      if (csFall || loadQ) txShift <= respNext;
      else if (sclkFall && bitCnt != '0) txShift <= {txShift[BYTE_W-2:0], 1'b0};

      if (strobe.latchCmd) irq <= 1'b1;
      else if (csRise || (byteDone && !isStart)) irq <= 1'b0;
    end
  end

  assign miso = txShift[BYTE_W-1];

  // R11
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && !isStart) |=> !irq);

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> cmdValid);

  // R4
  quiet_miso_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadQ && !cmdValid) |=> !miso);
endmodule

// File: rtl/spi_adc_datapath.sv
module spi_adc_datapath
  import spi_adc_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_CH)-1:0] wrCh,
  input  logic [BYTE_W-1:0]         wrData,
  output logic                      cmdValid,
  output logic [BYTE_W-1:0]         resFirst,
  output logic [BYTE_W-1:0]         resSecond
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [BYTE_W-1:0] TOP_DEFAULT = 8'hF0;
  localparam logic [BYTE_W-1:0] STEP        = 8'h10;
  localparam logic [BYTE_W-1:0] COM_REF     = 8'h00;
  localparam logic [BYTE_W-1:0] SIGN_FLIP   = 8'h80;

  logic [BYTE_W-1:0] inReg [NUM_CH];
  logic [CH_W-1:0]   selCh, pairCh;
  logic [BYTE_W-1:0] subtrahend, meas, coded;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_in
    always_ff @(posedge clk) begin
      if (!rstN) inReg[c] <= TOP_DEFAULT - BYTE_W'(c) * STEP;
      else if (wrEn && wrCh == CH_W'(c)) inReg[c] <= wrData;
    end
  end

  if (NUM_CH == 8) begin : g_map8
    assign selCh = {strobe.chSel[1], strobe.chSel[0], strobe.chSel[2]};
  end else begin : g_map4
    assign selCh = {strobe.chSel[1], strobe.chSel[2]};
  end

  assign pairCh     = selCh ^ CH_W'(1);
  assign subtrahend = strobe.singleEnded ? COM_REF : inReg[pairCh];
  assign meas       = inReg[selCh] - subtrahend;
  assign coded      = strobe.unipolar ? meas : (meas ^ SIGN_FLIP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      resFirst  <= '0;
      resSecond <= '0;
    end else if (strobe.latchCmd) begin
      cmdValid  <= 1'b1;
      resFirst  <= {2'b00, coded[BYTE_W-1:2]};
      resSecond <= {coded[1:0], 6'b000000};
    end else if (strobe.clearCmd) begin
      cmdValid  <= 1'b0;
    end
  end

  // R5
  result_fmt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resFirst[7:6] == 2'b00) && (resSecond[5:0] == 6'b0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.latchCmd || strobe.clearCmd) |=>
      ($stable(cmdValid) && $stable(resFirst) && $stable(resSecond)));

  // R4
  pwrdn_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCmd |=> !cmdValid);
endmodule

// File: rtl/spi_adc_responder.sv
module spi_adc_responder
  import spi_adc_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      csN,
  input  logic                      sclk,
  input  logic                      mosi,
  output logic                      miso,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_CH)-1:0] wrCh,
  input  logic [BYTE_W-1:0]         wrData,
  output logic                      irq
);
  ctrlStrobe_t       strobe;
  logic              cmdValid;
  logic [BYTE_W-1:0] resFirst, resSecond;

  spi_adc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .sclk      (sclk),
    .mosi      (mosi),
    .cmdValid  (cmdValid),
    .resFirst  (resFirst),
    .resSecond (resSecond),
    .miso      (miso),
    .irq       (irq),
    .strobe    (strobe)
  );

  spi_adc_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrEn      (wrEn),
    .wrCh      (wrCh),
    .wrData    (wrData),
    .cmdValid  (cmdValid),
    .resFirst  (resFirst),
    .resSecond (resSecond)
  );
endmodule

// File: tb/test_spi_adc_responder.sv
module test_spi_adc_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0;
  logic csNA = 1'b1, csNB = 1'b1;
  logic wrEnA = 1'b0, wrEnB = 1'b0;
  logic [2:0] wrChA = '0;
  logic [1:0] wrChB = '0;
  logic [7:0] wrDataA = '0, wrDataB = '0;
  logic misoA, misoB, irqA, irqB;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_adc_responder #(.NUM_CH(8)) i_spi_adc_responder (
    .clk(clk), .rstN(rstN), .csN(csNA), .sclk(sclk), .mosi(mosi), .miso(misoA),
    .wrEn(wrEnA), .wrCh(wrChA), .wrData(wrDataA), .irq(irqA));

  spi_adc_responder #(.NUM_CH(4)) i_spi_adc_responder_q (
    .clk(clk), .rstN(rstN), .csN(csNB), .sclk(sclk), .mosi(mosi), .miso(misoB),
    .wrEn(wrEnB), .wrCh(wrChB), .wrData(wrDataB), .irq(irqB));

  logic [7:0] modA [8];
  logic [7:0] modB [4];
  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] rxVal;
  event       rxEv;
  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops scoreboard entries as bytes come back
  initial begin
    forever begin
      @(rxEv);
      if (expQ.size() == 0) chk("scoreboard underflow", rxVal, 8'hxx);
      else chk(tagQ.pop_front(), rxVal, expQ.pop_front());
    end
  end

  task automatic push(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  task automatic setCs(input int dut, input logic v);
    if (dut == 0) csNA = v; else csNB = v;
    ticks(HALF);
  endtask

  task automatic spiByte(input int dut, input logic [7:0] tx);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      ticks(HALF);
      r[i] = (dut == 0) ? misoA : misoB;
      sclk = 1'b1;
      ticks(HALF);
      sclk = 1'b0;
    end
    ticks(HALF);
    rxVal = r;
    -> rxEv;
    ticks(1);
  endtask

  function automatic logic [7:0] mkCmd(input logic pwr, input logic [2:0] sel,
                                       input logic uni, input logic sgl);
    return {1'b1, sel[2], sel[1], sel[0], uni, sgl, pwr, 1'b0};
  endfunction

  function automatic logic [7:0] measOf(input int dut, input logic [7:0] c);
    int ch;
    logic [7:0] a, b, m;
    if (dut == 0) ch = int'({c[5], c[4], c[6]});
    else          ch = int'({c[5], c[6]});
    a = (dut == 0) ? modA[ch] : modB[ch];
    if (c[2]) b = 8'h00;
    else      b = (dut == 0) ? modA[ch ^ 1] : modB[ch ^ 1];
    m = a - b;
    if (!c[3]) m = m ^ 8'h80;
    return m;
  endfunction

  function automatic logic irqOf(input int dut);
    return (dut == 0) ? irqA : irqB;
  endfunction

  // full conversion: command, two result bytes, one trailing byte
  task automatic convert(input int dut, input logic [7:0] cmd, input logic [7:0] filler,
                         input string tag);
    logic [7:0] m;
    m = measOf(dut, cmd);
    push(8'h00, {tag, " R5 cmd byte"});
    push({2'b00, m[7:2]}, {tag, " R5 first"});
    push({m[1:0], 6'b0}, {tag, " R5 second"});
    push(8'h00, {tag, " R5 trailing"});
    setCs(dut, 1'b0);
    spiByte(dut, cmd);
    chk({tag, " R11 irq set"}, {7'b0, irqOf(dut)}, 8'h01);
    spiByte(dut, filler);
    chk({tag, " R11 irq cleared by filler"}, {7'b0, irqOf(dut)}, 8'h00);
    spiByte(dut, filler);
    spiByte(dut, filler);
    setCs(dut, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) modA[i] = 8'hF0 - 8'(i * 16);
    for (int i = 0; i < 4; i++) modB[i] = 8'hF0 - 8'(i * 16);
    ticks(5);
    rstN = 1'b1;
    ticks(2);

    // R1 reset state
    chk("R1 miso A", {7'b0, misoA}, 8'h00);
    chk("R1 irq A", {7'b0, irqA}, 8'h00);
    chk("R1 miso B", {7'b0, misoB}, 8'h00);
    chk("R1 irq B", {7'b0, irqB}, 8'h00);

    // R6 R8 R1: every select code, single-ended unipolar, reset defaults
    for (int s = 0; s < 8; s++) convert(0, mkCmd(1'b1, 3'(s), 1'b1, 1'b1), 8'h00, "R6 R8 R1");

    // R9: differential, both pair directions (wrap)
    for (int s = 0; s < 8; s++) convert(0, mkCmd(1'b1, 3'(s), 1'b1, 1'b0), 8'h00, "R9 R6");

    // R10: bipolar coding
    convert(0, mkCmd(1'b1, 3'b000, 1'b0, 1'b1), 8'h00, "R10 se");
    convert(0, mkCmd(1'b1, 3'b100, 1'b0, 1'b0), 8'h00, "R10 diff");

    // R12: write port
    @(negedge clk); wrEnA = 1'b1; wrChA = 3'd3; wrDataA = 8'h05;
    @(negedge clk); wrChA = 3'd2; wrDataA = 8'h10;
    @(negedge clk); wrEnA = 1'b0;
    modA[3] = 8'h05; modA[2] = 8'h10;
    // channel 3 = {sel1=0, sel0=1, sel2=1}
    convert(0, mkCmd(1'b1, 3'b101, 1'b1, 1'b0), 8'h00, "R12 R9 wrap");
    convert(0, mkCmd(1'b1, 3'b101, 1'b1, 1'b1), 8'h00, "R12 se");

    // R3: non-command fillers that look like other selections
    convert(0, mkCmd(1'b1, 3'b010, 1'b1, 1'b1), 8'h7B, "R3 filler");

    // R4: power-down command
    push(8'h00, "R4 cmd byte");
    push(8'h00, "R4 resp1");
    push(8'h00, "R4 resp2");
    push(8'h00, "R4 resp3");
    setCs(0, 1'b0);
    spiByte(0, mkCmd(1'b0, 3'b000, 1'b1, 1'b1));
    chk("R4 no irq", {7'b0, irqA}, 8'h00);
    spiByte(0, 8'h00); spiByte(0, 8'h00); spiByte(0, 8'h00);
    setCs(0, 1'b1);

    // R5 R11: read-out continues across a chip-select break
    begin
      logic [7:0] m;
      logic [7:0] c;
      c = mkCmd(1'b1, 3'b110, 1'b1, 1'b1);
      m = measOf(0, c);
      push(8'h00, "R5 split cmd");
      setCs(0, 1'b0);
      spiByte(0, c);
      setCs(0, 1'b1);
      chk("R11 irq cleared by cs", {7'b0, irqA}, 8'h00);
      push({2'b00, m[7:2]}, "R5 split first");
      push({m[1:0], 6'b0}, "R5 split second");
      push(8'h00, "R5 split trailing");
      setCs(0, 1'b0);
      spiByte(0, 8'h00); spiByte(0, 8'h00); spiByte(0, 8'h00);
      setCs(0, 1'b1);
    end

    // R2: aborted partial byte is discarded
    setCs(0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1; ticks(HALF); sclk = 1'b1; ticks(HALF); sclk = 1'b0;
    end
    setCs(0, 1'b1);
    convert(0, mkCmd(1'b1, 3'b001, 1'b1, 1'b1), 8'h00, "R2 after abort");

    // R7: 4-input variant, sel0 ignored
    for (int s = 0; s < 8; s++) convert(1, mkCmd(1'b1, 3'(s), 1'b1, 1'b1), 8'h00, "R7 R8");
    convert(1, mkCmd(1'b1, 3'b001, 1'b0, 1'b0), 8'h00, "R7 R9 R10");
    convert(1, mkCmd(1'b1, 3'b100, 1'b1, 1'b0), 8'h00, "R7 R9");

    ticks(10);
    if (expQ.size() != 0) chk("scoreboard leftover", 8'(expQ.size()), 8'h00);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule